// File: doc/BRIEF.md
# Timed Power Rail Sequencer

This block brings three supply rails up one after another once a power-up request arrives, and then lets the rest of the system out of reset. A free-running millisecond tick, restarted with each request, times every step. The request must stay high, with no gap, through a short qualification window and then through the lead-in delay. After that the lowest rail is switched on. Each rail's power-good input is looked at exactly once, a fixed time after that rail's own enable. A pass switches on the next rail. A fail freezes the sequence with a fault flag raised and the system reset held low.

When the third rail passes its check, a final hold interval runs and the active-low system reset is released. Dropping the request at any point returns the block to its idle state: every enable off, reset asserted, fault cleared. This drop is also the only way out of a fault. All durations are parameters counted in ticks, and the clocks-per-tick count is itself a parameter, so a simulation can compress milliseconds to a few dozen clocks. The request and the three power-good inputs come from outside the clock domain and pass through two-flop synchronisers.

Top module: `pwr_rail_seq`

## Requirements
- R1: While `rst` is high and after it is released with the request low, `rail_en` is 3'b000, `sys_rst_n` is 0 and `seq_fault` is 0.
- R2: Bit 0 of `rail_en` (lowest rail) rises LEAD_MS ticks after the synchronised request goes high. One tick is CLKS_PER_MS clocks, and the synchronised request lags `pwr_req` by two clocks.
- R3: Rails are enabled in the order bit 0, bit 1, bit 2. Bit k+1 rises CHECK_MS ticks after bit k, and only if rail k passed its check. No higher bit is ever set without every lower bit set.
- R4: Rail k's good input (`good_in[k]`) is sampled only at its checkpoint, CHECK_MS ticks after `rail_en[k]` rises. A rail that becomes good at any time before the checkpoint passes, whether it was good from the start or only shortly before the check.
- R5: If a rail's good input is low at its checkpoint, `seq_fault` goes high. No further rail is enabled, `sys_rst_n` stays 0, and the already-enabled rails remain on until the request is dropped.
- R6: `sys_rst_n` rises RELEASE_MS ticks after the checkpoint of rail 2 passes, with all three enables high and `seq_fault` low.
- R7: Within three clocks of `pwr_req` going low, from any state, `rail_en` is 3'b000, `sys_rst_n` is 0 and `seq_fault` is 0.
- R8: The request must stay high without interruption. A low sample during the qualification window or the lead-in restarts timing from the next rising edge, so no rail is enabled on the strength of the earlier pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pwr_req | input | 1 | Power-up request, asynchronous |
| good_in | input | 3 | Per-rail power-good comparator outputs, asynchronous; bit k belongs to rail k |
| rail_en | output | 3 | Rail enables; bit 0 is the lowest rail, bit 2 the highest |
| sys_rst_n | output | 1 | Active-low system reset, released at the end of a successful sequence |
| seq_fault | output | 1 | High after a failed rail check, until the request is dropped |

## Verification
The bench drives rails that turn good only a few clocks before their checkpoint. A design that monitored the inputs continuously, or sampled them too early, would raise the fault there. It also drives rails that never turn good, once for each of the three positions. A design with an off-by-one rail index, or one that carried on after a failed check, would enable a rail it must not or release reset. A short request pulse followed by a real one catches a lead-in timer that is not restarted by a low sample: such a design would switch on the lowest rail too early. Dropping the request mid-sequence and after a fault shows whether enables linger or the fault fails to clear.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    localparam int NUM_RAILS = 3;
    localparam int IDX_W     = $clog2(NUM_RAILS);

    typedef logic [IDX_W-1:0] rail_idx_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_RAIL,
        S_HOLD,
        S_DONE,
        S_FAULT
    } seq_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Enables for rails 0..k inclusive.
    function automatic logic [NUM_RAILS-1:0] upto_mask(input rail_idx_t k);
        logic [NUM_RAILS-1:0] m;
        for (int i = 0; i < NUM_RAILS; i++) begin
            m[i] = (i <= int'(k));
        end
        return m;
    endfunction

endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/ms_tick.sv
module ms_tick #(
    parameter int CLKS_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    generate
        if (CLKS_PER_MS > 1) begin : g_spacing
            // R2: ticks are isolated pulses, never back to back
            a_r2_tick_isolated: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/req_qual.sv
module req_qual #(
    parameter int QUAL_TICKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic req_s,
    input  logic tick,
    output logic ok
);
    localparam int QW = $clog2(QUAL_TICKS + 1);
    localparam logic [QW-1:0] QLAST = QW'(QUAL_TICKS - 1);

    logic [QW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !req_s) begin
            cnt <= '0;
            ok  <= 1'b0;
        end else if (tick && !ok) begin
            if (cnt == QLAST) begin
                ok <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R8: qualification only completes on a tick boundary
    a_r8_ok_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(ok) |-> $past(tick));
    // R8: a low request sample withdraws qualification at once
    a_r8_ok_drops: assert property (@(posedge clk) disable iff (rst)
        !req_s |=> !ok);
endmodule

// File: rtl/pwr_rail_seq.sv
module pwr_rail_seq
    import pwrseq_pkg::*;
#(
    parameter int CLKS_PER_MS = 50000,
    parameter int QUAL_TICKS  = 3,
    parameter int LEAD_MS     = 11,
    parameter int CHECK_MS    = 10,
    parameter int RELEASE_MS  = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pwr_req,
    input  logic [NUM_RAILS-1:0] good_in,
    output logic [NUM_RAILS-1:0] rail_en,
    output logic                 sys_rst_n,
    output logic                 seq_fault
);
    localparam int TMAX = max3(LEAD_MS, CHECK_MS, RELEASE_MS);
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] LEAD_LAST = TW'(LEAD_MS - QUAL_TICKS - 1);
    localparam logic [TW-1:0] CHK_LAST  = TW'(CHECK_MS - 1);
    localparam logic [TW-1:0] REL_LAST  = TW'(RELEASE_MS - 1);
    localparam rail_idx_t     TOP_IDX   = IDX_W'(NUM_RAILS - 1);

    typedef struct packed {
        seq_state_e    st;
        rail_idx_t     idx;
        logic [TW-1:0] tmr;
    } seq_t;

    logic                 req_s;
    logic [NUM_RAILS-1:0] good_s;
    logic                 tick;
    logic                 req_ok;
    seq_t                 cur, nxt;

    sync_2ff #(.W(NUM_RAILS + 1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({good_in, pwr_req}),
        .q   ({good_s, req_s})
    );

    ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (req_s),
        .tick (tick)
    );

    req_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
        .clk   (clk),
        .rst   (rst),
        .req_s (req_s),
        .tick  (tick),
        .ok    (req_ok)
    );

    always_comb begin
        nxt = cur;
        if (!req_s) begin
            nxt = '{st: S_IDLE, idx: '0, tmr: '0};
        end else begin
            unique case (cur.st)
                S_IDLE: begin
                    if (req_ok) begin
                        nxt.st  = S_LEAD;
                        nxt.tmr = '0;
                    end
                end
                S_LEAD: begin
                    if (tick) begin
                        if (cur.tmr == LEAD_LAST) begin
                            nxt.st  = S_RAIL;
                            nxt.idx = '0;
                            nxt.tmr = '0;
                        end else begin
                            nxt.tmr = cur.tmr + 1'b1;
                        end
                    end
                end
                S_RAIL: begin
                    if (tick) begin
                        if (cur.tmr == CHK_LAST) begin
                            nxt.tmr = '0;
                            if (!good_s[cur.idx]) begin
                                nxt.st = S_FAULT;
                            end else if (cur.idx == TOP_IDX) begin
                                nxt.st = S_HOLD;
                            end else begin
                                nxt.idx = cur.idx + 1'b1;
                            end
                        end else begin
                            nxt.tmr = cur.tmr + 1'b1;
                        end
                    end
                end
                S_HOLD: begin
                    if (tick) begin
                        if (cur.tmr == REL_LAST) begin
                            nxt.st  = S_DONE;
                            nxt.tmr = '0;
                        end else begin
                            nxt.tmr = cur.tmr + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '{st: S_IDLE, idx: '0, tmr: '0};
        end else begin
            cur <= nxt;
        end
    end

    always_comb begin
        unique case (cur.st)
            S_RAIL, S_FAULT: rail_en = upto_mask(cur.idx);
            S_HOLD, S_DONE:  rail_en = '1;
            default:         rail_en = '0;
        endcase
    end

    assign sys_rst_n = (cur.st == S_DONE);
    assign seq_fault = (cur.st == S_FAULT);

    // R7: a dropped request clears everything on the next clock
    a_r7_drop_idle: assert property (@(posedge clk) disable iff (rst)
        !req_s |=> (rail_en == '0 && !sys_rst_n && !seq_fault));
    // R5: the fault persists while the request stays high
    a_r5_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        (seq_fault && req_s) |=> seq_fault);
    // R6: release only with every rail on and no fault
    a_r6_release_full: assert property (@(posedge clk) disable iff (rst)
        sys_rst_n |-> (rail_en == '1 && !seq_fault));
    // R2: the first enable appears only on a tick
    a_r2_first_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(rail_en[0]) |-> $past(tick));

    generate
        for (genvar g = 1; g < NUM_RAILS; g++) begin : g_order
            // R3: a higher rail never runs without the one below it
            a_r3_order: assert property (@(posedge clk) disable iff (rst)
                rail_en[g] |-> rail_en[g-1]);
            // R4: the next rail rises only after the previous rail read good
            a_r4_pass_first: assert property (@(posedge clk) disable iff (rst)
                $rose(rail_en[g]) |-> ($past(good_s[g-1]) && $past(tick)));
        end
    endgenerate
endmodule

// File: tb/tb_pwr_rail_seq.sv
module tb_pwr_rail_seq;

    localparam int CPM  = 20;
    localparam int QT   = 3;
    localparam int LEAD = 11;
    localparam int CHK  = 10;
    localparam int REL  = 10;

    typedef struct packed {
        logic       early;
        logic [1:0] fail;   // 3 means all rails pass
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{early: 1'b0, fail: 2'd3},
        '{early: 1'b1, fail: 2'd3},
        '{early: 1'b0, fail: 2'd0},
        '{early: 1'b1, fail: 2'd1},
        '{early: 1'b0, fail: 2'd2}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_req = 1'b0;
    logic [2:0] good_in = 3'b000;
    logic [2:0] rail_en;
    logic       sys_rst_n;
    logic       seq_fault;

    int checks = 0;
    int fails  = 0;
    int edge_n = 0;
    int base   = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) edge_n <= edge_n + 1;

    pwr_rail_seq #(
        .CLKS_PER_MS(CPM), .QUAL_TICKS(QT), .LEAD_MS(LEAD),
        .CHECK_MS(CHK), .RELEASE_MS(REL)
    ) dut (
        .clk(clk), .rst(rst), .pwr_req(pwr_req), .good_in(good_in),
        .rail_en(rail_en), .sys_rst_n(sys_rst_n), .seq_fault(seq_fault)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Wait until x clocks after the synchronised request went high, sample mid-cycle.
    task automatic at_rel(input int x);
        do @(negedge clk); while (edge_n < base + 2 + x);
    endtask

    task automatic raise_req();
        @(negedge clk);
        pwr_req = 1'b1;
        base = edge_n;
    endtask

    function automatic int en_time(input int i);
        return (LEAD + CHK * i) * CPM;
    endfunction

    task automatic run_vec(input vec_t v);
        int f;
        f = int'(v.fail);
        pwr_req = 1'b0;
        good_in = 3'b000;
        repeat (10) @(negedge clk);
        chk("R7", "idle enables", 32'(rail_en), 0);
        chk("R7", "idle fault", 32'(seq_fault), 0);
        if (v.early) begin
            for (int i = 0; i < 3; i++) good_in[i] = (i != f);
        end
        raise_req();
        for (int i = 0; i < 3; i++) begin
            if (i > f) begin
                at_rel(en_time(i) + 3);
                chk("R5", "no enable after fail", 32'(rail_en[i]), 0);
                break;
            end
            at_rel(en_time(i) - 3);
            chk(i == 0 ? "R2" : "R3", "enable before time", 32'(rail_en[i]), 0);
            at_rel(en_time(i) + 3);
            chk(i == 0 ? "R2" : "R3", "enable on time", 32'(rail_en[i]), 1);
            if (!v.early && i != f) begin
                at_rel(en_time(i) + CHK * CPM - 6);
                good_in[i] = 1'b1;
            end
            at_rel(en_time(i) + CHK * CPM - 3);
            chk("R4", "no fault before checkpoint", 32'(seq_fault), 0);
            if (i == f) begin
                at_rel(en_time(i) + CHK * CPM + 3);
                chk("R5", "fault at checkpoint", 32'(seq_fault), 1);
                chk("R5", "enables held", 32'(rail_en), 32'((1 << (i + 1)) - 1));
            end
        end
        if (f == 3) begin
            at_rel((LEAD + 3 * CHK + REL) * CPM - 3);
            chk("R6", "reset held before release", 32'(sys_rst_n), 0);
            at_rel((LEAD + 3 * CHK + REL) * CPM + 3);
            chk("R6", "reset released", 32'(sys_rst_n), 1);
            chk("R6", "all rails on", 32'(rail_en), 32'h7);
        end else begin
            at_rel((LEAD + 3 * CHK + REL) * CPM + 3);
            chk("R5", "reset stays low after fault", 32'(sys_rst_n), 0);
            chk("R5", "fault still high", 32'(seq_fault), 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: outputs inactive during and after reset
        repeat (4) @(negedge clk);
        chk("R1", "enables in reset", 32'(rail_en), 0);
        chk("R1", "sys_rst_n in reset", 32'(sys_rst_n), 0);
        chk("R1", "fault in reset", 32'(seq_fault), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1", "enables after reset", 32'(rail_en), 0);
        chk("R1", "sys_rst_n after reset", 32'(sys_rst_n), 0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R7: dropping the request after a fault clears it
        pwr_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7", "fault cleared by drop", 32'(seq_fault), 0);
        chk("R7", "enables cleared by drop", 32'(rail_en), 0);

        // R8: a short pulse followed by a real request restarts timing
        good_in = 3'b111;
        repeat (10) @(negedge clk);
        raise_req();
        repeat (2 * CPM) @(negedge clk);
        pwr_req = 1'b0;
        repeat (5) @(negedge clk);
        begin
            int first_base;
            first_base = base;
            raise_req();
            do @(negedge clk); while (edge_n < first_base + 2 + en_time(0) + 3);
            chk("R8", "no enable from the short pulse", 32'(rail_en[0]), 0);
        end
        at_rel(en_time(0) + 3);
        chk("R8", "enable from the held request", 32'(rail_en[0]), 1);

        // R7: drop in the middle of the sequence
        at_rel(en_time(1) + 3);
        chk("R3", "second rail on before drop", 32'(rail_en), 32'h3);
        pwr_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7", "mid-sequence drop enables", 32'(rail_en), 0);
        chk("R7", "mid-sequence drop reset", 32'(sys_rst_n), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule